// File: doc/BRIEF.md
# Serial PHY Management Frame Master

This block runs the two-wire serial management link that a MAC uses to reach the registers of one or more Ethernet PHYs. The clock line is generated inside the block. The data line is bidirectional: the block drives a value and an output-enable, and the pad logic outside the block combines them. The block samples the returned line on a separate input.

A request gives a PHY address, a register address, a direction and, for a write, sixteen data bits. The block then shifts out one frame and raises `done` for one cycle. After a read, `done` also marks the cycle in which the fetched value appears on `rdData`.

The frame can start with a run of 32 driven ones. These resynchronise PHYs that cannot accept frames without this lead-in. The caller turns the run on when any attached PHY has status bit 6 clear, meaning it does not tolerate a suppressed lead-in. Otherwise the caller leaves the run out to shorten every access by 32 bit times.

Top module: `mdio_frame_master`

## Requirements
- R1: During reset and directly after it, `mdc`, `mdoEn`, `mdoOut`, `busy` and `done` are low and `rdData` is zero.
- R2: `mdc` idles low. Each of its half periods lasts HALF_CYC system clocks, so one bit time is 2*HALF_CYC clocks. The default of 10 gives 2.5 MHz from a 50 MHz clock, the highest rate allowed.
- R3: With `reqPreamble` high when a request is accepted, the first 32 bit times carry a driven 1. With it low, the command starts in the first bit time.
- R4: A read drives 16 command bits, most significant first: 1,1,0,1,1,0, then `phyAddr[4:0]`, then `regAddr[4:0]`.
- R5: After the read command, the line is released for 19 bit times. `mdiIn` is taken at each rising `mdc` edge, using the value held while `mdc` was low. Call the first sample bit 18 and the last bit 0. At `done`, `rdData` takes bits 16 down to 1.
- R6: A write drives 32 bits, most significant first: 0,1,0,1, `phyAddr`, `regAddr`, 1,0, `wrData[15:0]`. The line is then released for 2 bit times.
- R7: `mdoOut` and `mdoEn` change only together with a falling `mdc` edge or at acceptance, never at a rising edge.
- R8: `mdoEn` is high exactly during the lead-in and command bits. While the line is released, `mdoOut` is 0.
- R9: `busy` is high from the cycle after acceptance. `done` is a single-cycle pulse, in the cycle where `busy` falls. It arrives N*2*HALF_CYC clocks after the accepting edge, where N is the frame's bit count.
- R10: A request raised while `busy` is high is ignored, and so are address or data changes during a frame. `rdData` changes only at the `done` of a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Start a frame; accepted only when idle |
| reqWrite | input | 1 | 1 = write frame, 0 = read frame |
| reqPreamble | input | 1 | Send the 32-bit lead-in of ones |
| phyAddr | input | 5 | Target PHY address |
| regAddr | input | 5 | Target register address |
| wrData | input | 16 | Data for a write frame |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| rdData | output | 16 | Value returned by the last read |
| mdc | output | 1 | Management clock |
| mdoOut | output | 1 | Value driven onto the data line |
| mdoEn | output | 1 | Drive enable for the data line |
| mdiIn | input | 1 | Sampled data line |

## Verification
Every result falls due at a fixed count of clocks after the accepting edge. The first rising `mdc` comes HALF_CYC clocks after that edge, and each later bit adds 2*HALF_CYC. `done`, the fall of `busy` and the new `rdData` all land N*2*HALF_CYC clocks after acceptance. The bench counts falling system-clock edges from acceptance and compares that count with the value it computes from the frame length. It logs the line at each rising `mdc` and feeds the read bits from the same edge. It therefore samples where the PHY would, and leaves every value a full half period to settle.

// File: rtl/mdio_master_pkg.sv
`timescale 1ns/1ps
package mdio_master_pkg;

  // Strobes from the sequencer to the shift datapath
  typedef struct packed {
    logic load;      // capture request fields into the shift register
    logic shift;     // advance command shift register by one bit
    logic sample;    // capture one returned bit
    logic commit;    // publish collected read value
    logic drivePre;  // drive constant one (lead-in)
    logic driveEn;   // master owns the data line
  } mdioStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_CMD,
    ST_RDPH,
    ST_WRTAIL
  } mdioState_t;

endpackage

// File: rtl/mdio_master_ctrl.sv
`timescale 1ns/1ps
module mdio_master_ctrl
  import mdio_master_pkg::*;
#(
  parameter int HALF_CYC    = 10,
  parameter int PRE_BITS    = 32,
  parameter int RD_CMD_BITS = 16,
  parameter int WR_BITS     = 32,
  parameter int RD_BITS     = 19,
  parameter int TAIL_BITS   = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic        reqPreamble,
  output logic        busy,
  output logic        done,
  output logic        mdc,
  output mdioStrobe_t strb
);

  localparam int HW    = $clog2(HALF_CYC + 1);
  localparam int CNT_W = $clog2(PRE_BITS + WR_BITS + RD_BITS + 1);

  mdioState_t       state;
  logic [HW-1:0]    halfCnt;
  logic [CNT_W-1:0] bitCnt;
  logic             isWrite;
  logic             mdcQ;
  logic             doneQ;

  logic halfEnd, bitEnd, lastBit, accept;

  assign busy    = (state != ST_IDLE);
  assign accept  = reqValid && (state == ST_IDLE);
  assign halfEnd = busy && (halfCnt == HW'(HALF_CYC - 1));
  assign bitEnd  = halfEnd && mdcQ;
  assign lastBit = (bitCnt == '0);
  assign mdc     = mdcQ;
  assign done    = doneQ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      halfCnt <= '0;
      bitCnt  <= '0;
      isWrite <= 1'b0;
      mdcQ    <= 1'b0;
      doneQ   <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (accept) begin
        isWrite <= reqWrite;
        halfCnt <= '0;
        mdcQ    <= 1'b0;
        if (reqPreamble) begin
          state  <= ST_PRE;
          bitCnt <= CNT_W'(PRE_BITS - 1);
        end else begin
          state  <= ST_CMD;
          bitCnt <= reqWrite ? CNT_W'(WR_BITS - 1) : CNT_W'(RD_CMD_BITS - 1);
        end
      end else if (busy) begin
        halfCnt <= halfEnd ? '0 : halfCnt + 1'b1;
        if (halfEnd) mdcQ <= ~mdcQ;
        if (bitEnd) begin
          if (!lastBit) begin
            bitCnt <= bitCnt - 1'b1;
          end else begin
            unique case (state)
              ST_PRE: begin
                state  <= ST_CMD;
                bitCnt <= isWrite ? CNT_W'(WR_BITS - 1) : CNT_W'(RD_CMD_BITS - 1);
              end
              ST_CMD: begin
                state  <= isWrite ? ST_WRTAIL : ST_RDPH;
                bitCnt <= isWrite ? CNT_W'(TAIL_BITS - 1) : CNT_W'(RD_BITS - 1);
              end
              default: begin
                state <= ST_IDLE;
                doneQ <= 1'b1;
              end
            endcase
          end
        end
      end
    end
  end

  always_comb begin
    strb          = '0;
    strb.load     = accept;
    strb.shift    = bitEnd && (state == ST_CMD);
    strb.sample   = halfEnd && !mdcQ && (state == ST_RDPH);
    strb.commit   = bitEnd && lastBit && (state == ST_RDPH);
    strb.drivePre = (state == ST_PRE);
    strb.driveEn  = (state == ST_PRE) || (state == ST_CMD);
  end

  // Checker state: cycles since the clock line last changed level
  logic          mdcPrev;
  logic [HW-1:0] sinceEdge;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mdcPrev   <= 1'b0;
      sinceEdge <= HW'(HALF_CYC);
    end else begin
      mdcPrev <= mdcQ;
      if (mdcQ != mdcPrev)                 sinceEdge <= '0;
      else if (sinceEdge != HW'(HALF_CYC)) sinceEdge <= sinceEdge + 1'b1;
    end
  end

  AST_HALF_PERIOD_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    (mdcQ != mdcPrev) |-> (sinceEdge >= HW'(HALF_CYC - 1))); // R2
  AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdcQ); // R2
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))); // R9
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bitEnd) |=> busy); // R10

endmodule

// File: rtl/mdio_master_dp.sv
`timescale 1ns/1ps
module mdio_master_dp
  import mdio_master_pkg::*;
#(
  parameter int PHY_W   = 5,
  parameter int REG_W   = 5,
  parameter int DATA_W  = 16,
  parameter int FRAME_W = 6 + PHY_W + REG_W + DATA_W,
  parameter int RD_BITS = DATA_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  mdioStrobe_t       strb,
  input  logic              reqWrite,
  input  logic [PHY_W-1:0]  phyAddr,
  input  logic [REG_W-1:0]  regAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              mdiIn,
  output logic              mdoOut,
  output logic              mdoEn,
  output logic [DATA_W-1:0] rdData
);

  logic [FRAME_W-1:0] shreg;
  logic [RD_BITS-1:0] cap;
  logic [FRAME_W-1:0] loadVal;

  // Read: two extra ones, start 01, opcode 10, addresses; write: start 01, opcode 01, addresses, turnaround 10, data
  always_comb begin
    if (reqWrite) loadVal = {4'b0101, phyAddr, regAddr, 2'b10, wrData};
    else          loadVal = {6'b110110, phyAddr, regAddr, {DATA_W{1'b0}}};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg  <= '0;
      cap    <= '0;
      rdData <= '0;
    end else begin
      if (strb.load) begin
        shreg <= loadVal;
        cap   <= '0;
      end else begin
        if (strb.shift)  shreg <= {shreg[FRAME_W-2:0], 1'b0};
        if (strb.sample) cap   <= {cap[RD_BITS-2:0], mdiIn};
      end
      if (strb.commit) rdData <= cap[DATA_W:1];
    end
  end

  assign mdoEn  = strb.driveEn;
  assign mdoOut = strb.driveEn && (strb.drivePre || shreg[FRAME_W-1]);

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.commit |=> $stable(rdData)); // R10
  AST_NO_SHIFT_WHILE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    strb.sample |-> !strb.driveEn); // R8

endmodule

// File: rtl/mdio_frame_master.sv
`timescale 1ns/1ps
module mdio_frame_master
  import mdio_master_pkg::*;
#(
  parameter int HALF_CYC = 10,
  parameter int PRE_BITS = 32,
  parameter int PHY_W    = 5,
  parameter int REG_W    = 5,
  parameter int DATA_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqPreamble,
  input  logic [PHY_W-1:0]  phyAddr,
  input  logic [REG_W-1:0]  regAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdData,
  output logic              mdc,
  output logic              mdoOut,
  output logic              mdoEn,
  input  logic              mdiIn
);

  localparam int RD_CMD_BITS = 6 + PHY_W + REG_W;
  localparam int WR_BITS     = RD_CMD_BITS + DATA_W;
  localparam int RD_BITS     = DATA_W + 3;
  localparam int TAIL_BITS   = 2;

  mdioStrobe_t strb;

  mdio_master_ctrl #(
    .HALF_CYC(HALF_CYC), .PRE_BITS(PRE_BITS), .RD_CMD_BITS(RD_CMD_BITS),
    .WR_BITS(WR_BITS), .RD_BITS(RD_BITS), .TAIL_BITS(TAIL_BITS)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqPreamble(reqPreamble), .busy(busy), .done(done), .mdc(mdc), .strb(strb)
  );

  mdio_master_dp #(
    .PHY_W(PHY_W), .REG_W(REG_W), .DATA_W(DATA_W),
    .FRAME_W(WR_BITS), .RD_BITS(RD_BITS)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .reqWrite(reqWrite),
    .phyAddr(phyAddr), .regAddr(regAddr), .wrData(wrData), .mdiIn(mdiIn),
    .mdoOut(mdoOut), .mdoEn(mdoEn), .rdData(rdData)
  );

  AST_SETUP_BEFORE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdc) |-> ($stable(mdoOut) && $stable(mdoEn))); // R7
  AST_DRIVE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    mdoEn |-> busy); // R8

endmodule

// File: tb/mdio_frame_master_tb.sv
`timescale 1ns/1ps
module mdio_frame_master_tb;

  localparam int H = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0, reqPreamble = 1'b0;
  logic [4:0]  phyAddr = '0, regAddr = '0;
  logic [15:0] wrData = '0;
  logic        mdiIn = 1'b1;
  wire         busy, done, mdc, mdoOut, mdoEn;
  wire  [15:0] rdData;

  mdio_frame_master u_dut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqPreamble(reqPreamble), .phyAddr(phyAddr), .regAddr(regAddr),
    .wrData(wrData), .busy(busy), .done(done), .rdData(rdData),
    .mdc(mdc), .mdoOut(mdoOut), .mdoEn(mdoEn), .mdiIn(mdiIn)
  );

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  int cyc = 0;
  int lastRise = -1;
  int minGap = 1000000;
  int nRise = 0;
  int relCnt = 0;
  logic [18:0] rdPat = '1;
  logic logOe [0:127];
  logic logD  [0:127];

  always @(posedge clk) cyc++;

  // PHY side: log the line at every rising clock edge, supply the next returned bit
  always @(posedge mdc) begin
    if (nRise < 128) begin
      logOe[nRise] = mdoEn;
      logD[nRise]  = mdoOut;
    end
    nRise++;
    if (lastRise >= 0 && (cyc - lastRise) < minGap) minGap = cyc - lastRise;
    lastRise = cyc;
    if (!mdoEn) begin
      relCnt++;
      mdiIn = (relCnt <= 18) ? rdPat[18 - relCnt] : 1'b1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // One frame: drive request, optionally inject an ignored request, check timing, line bits and result
  task automatic runFrame(input bit wr, input bit pre, input logic [4:0] pa,
                          input logic [4:0] ra, input logic [15:0] wd,
                          input logic [18:0] pat, input bit inject);
    logic expOe [0:127];
    logic expD  [0:127];
    int total = 0;
    int cnt = 0;
    bit busyOk = 1'b1;
    logic [31:0] cmd;
    int cmdLen;
    logic [15:0] oldRd = rdData;
    if (pre) for (int i = 0; i < 32; i++) begin expOe[total] = 1'b1; expD[total] = 1'b1; total++; end
    if (wr) begin cmd = {4'b0101, pa, ra, 2'b10, wd}; cmdLen = 32; end
    else    begin cmd = {6'b110110, pa, ra, 16'h0}; cmdLen = 16; end
    for (int i = 0; i < cmdLen; i++) begin expOe[total] = 1'b1; expD[total] = cmd[31 - i]; total++; end
    for (int i = 0; i < (wr ? 2 : 19); i++) begin expOe[total] = 1'b0; expD[total] = 1'b0; total++; end

    @(negedge clk);
    rdPat = pat; relCnt = 0; mdiIn = pat[18]; nRise = 0; lastRise = -1;
    reqWrite = wr; reqPreamble = pre; phyAddr = pa; regAddr = ra; wrData = wd; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    while (!done && cnt < 5000) begin
      if (!busy) busyOk = 1'b0;
      if (inject && cnt == 300) begin
        reqValid = 1'b1; reqWrite = ~wr; phyAddr = ~pa; regAddr = ~ra; wrData = ~wd; reqPreamble = ~pre;
      end
      if (inject && cnt == 301) reqValid = 1'b0;
      @(negedge clk);
      cnt++;
    end
    chk(busyOk, "R9 busy held until done", busyOk, 1);
    chk(cnt == total * 2 * H, "R9 done latency", cnt, total * 2 * H);
    chk(!busy, "R9 busy low with done", busy, 0);
    @(negedge clk);
    chk(!done, "R9 done single pulse", done, 0);
    chk(nRise == total, wr ? "R6 bit count" : "R5 bit count", nRise, total);
    begin
      int bad = -1;
      for (int i = 0; i < total && i < 128; i++)
        if (bad < 0 && (logOe[i] !== expOe[i] || logD[i] !== expD[i])) bad = i;
      chk(bad < 0, pre ? "R3 R4 R6 R8 line bits" : "R4 R6 R8 line bits",
          (bad < 0) ? 0 : {logOe[bad], logD[bad]}, (bad < 0) ? 0 : {expOe[bad], expD[bad]});
    end
    chk(minGap == 2 * H, "R2 clock period", minGap, 2 * H);
    if (wr) chk(rdData == oldRd, "R10 read value kept over write", rdData, oldRd);
    else    chk(rdData == pat[16:1], "R5 read value", rdData, pat[16:1]);
    if (inject) begin
      int r0 = nRise;
      repeat (200) begin
        @(negedge clk);
        if (busy) busyOk = 1'b0;
      end
      chk(busyOk && nRise == r0, "R10 request while busy ignored", nRise, r0);
    end
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    chk(!mdc && !mdoEn && !mdoOut && !busy && !done && rdData == 0, "R1 reset state",
        {mdc, mdoEn, mdoOut, busy, done, rdData}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(!mdc && !mdoEn && !busy && !done, "R1 idle after reset", {mdc, mdoEn, busy, done}, 0);
  endtask

  task automatic testReadPre();   runFrame(1'b0, 1'b1, 5'd1,  5'd1,  16'h0,    {2'b10, 16'hA5C3, 1'b1}, 1'b0); endtask
  task automatic testReadNoPre(); runFrame(1'b0, 1'b0, 5'd31, 5'd0,  16'h0,    {2'b11, 16'h8001, 1'b1}, 1'b0); endtask
  task automatic testWritePre();  runFrame(1'b1, 1'b1, 5'd5,  5'd18, 16'h1234, 19'h7FFFF, 1'b0); endtask
  task automatic testWriteNoPre();runFrame(1'b1, 1'b0, 5'd0,  5'd31, 16'hFFFF, 19'h0, 1'b0); endtask
  task automatic testIgnore();    runFrame(1'b0, 1'b0, 5'd10, 5'd21, 16'h0,    {2'b00, 16'h3C5A, 1'b0}, 1'b1); endtask

  bit finished = 1'b0;

  initial begin
    testReset();
    testReadPre();
    testReadNoPre();
    testWritePre();
    testWriteNoPre();
    testIgnore();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule